// File: doc/BRIEF.md
# SDRAM Bank State Monitor

This block watches the command bus of a four-bank single-data-rate SDRAM and checks every command against the device's command rules. Each clock it decodes the chip-select, row-strobe, column-strobe and write-enable lines together with the bank field and address bit 10. It keeps a per-bank record of whether a row is open, and it runs down counters that block each command until the required number of cycles has passed.

When a command breaks a rule, the block raises a one-cycle error pulse in the cycle after the command. The pulse carries a 4-bit code for the kind of breach and the bank involved. The block then updates its state as if the device had accepted the command, so a single mistake produces a single report and does not set off a chain of follow-on reports. It is meant to sit beside a memory controller in simulation or on silicon as a protocol guard. All minimum spacings are parameters, counted in clocks.

Top module: `sdram_bank_monitor`

## Requirements
- R1: The bus `{cs_n,ras_n,cas_n,we_n}` decodes as follows: `cs_n`=1 is deselect, 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0110 BURST STOP, 0010 PRECHARGE, 0001 REFRESH, 0000 MODE LOAD. Deselect and NOP change no state and never raise an error, whatever the other lines carry.
- R2: ACTIVE opens the bank named by `ba`. A READ or WRITE to a bank with no open row gives code 2. An ACTIVE to a bank that is already open gives code 3, and the bank stays open.
- R3: PRECHARGE with `addr[10]`=0 closes only the bank named by `ba`. With `addr[10]`=1 it closes every bank and `ba` has no effect. A PRECHARGE to an idle bank is legal and does nothing.
- R4: A READ or WRITE with `addr[10]`=1 to an open bank closes that bank by itself. The close happens as an implicit precharge in the cycle that is BL cycles after the command. BL comes from the mode field `addr[2:0]` of the last MODE LOAD: 0→1, 1→2, 2→4, 3→8. Any other value (7 is full page) means no automatic close. When mode bit `addr[9]`=1, WRITE uses BL=1. After reset the mode is BL=1 with `addr[9]`=0.
- R5: MODE LOAD while any bank is open gives code 4, with `err_bank` set to the lowest open bank. Any command other than deselect or NOP fewer than T_MRD cycles after a MODE LOAD gives code 1.
- R6: Spacings within one bank, counted in cycles between command cycles (a gap ≥ T is legal): ACTIVE→READ/WRITE below T_RCD gives code 10; ACTIVE→PRECHARGE below T_RAS gives code 11; close→ACTIVE below T_RP gives code 7; ACTIVE→ACTIVE below T_RC gives code 8. A precharge-all that catches a bank inside T_RAS reports the lowest such bank.
- R7: An ACTIVE fewer than T_RRD cycles after an ACTIVE to a different bank gives code 9.
- R8: REFRESH while any bank is open gives code 5, with the lowest open bank. An ACTIVE fewer than T_RFC cycles after a REFRESH gives code 6.
- R9: Each command reports at most one breach. When several apply, the lowest code wins. `err_valid` is high for exactly the one cycle after the offending command. `err_bank` is the command's `ba` unless a rule above names another bank.
- R10: After reset all banks are idle, every counter is clear and `err_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank field |
| addr | input | ADDR_W (12) | Address bus; bit 10 is the precharge selector, bits 2:0 and 9 are mode fields |
| bank_open | output | NUM_BANKS (4) | One bit per bank, high while a row is open |
| err_valid | output | 1 | One-cycle breach pulse |
| err_code | output | 4 | Breach code |
| err_bank | output | BA_W (2) | Bank tied to the breach |

## Verification
The assertions assume that the bus lines are known after reset and that `ba` never names a bank beyond NUM_BANKS. They also assume that no explicit command targets a bank in the same cycle as its implicit precharge; when that does happen, the explicit command takes precedence. The bench respects these limits: it drives only defined opcodes, and it starts a fresh reset before each sweep point, so no auto-close timer is pending when a new sequence begins. It then sweeps every gap from one cycle past each spacing limit down to a single cycle, computing the expected code from the gap and the limit.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;

  localparam int LEN_W = 4;

  typedef enum logic [3:0] {
    CMD_INH, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
    CMD_BST, CMD_PRE, CMD_REF, CMD_LMR
  } cmd_e;

  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_MRD      = 4'd1,
    ERR_NOROW    = 4'd2,
    ERR_ROWOPEN  = 4'd3,
    ERR_MODEBUSY = 4'd4,
    ERR_REFBUSY  = 4'd5,
    ERR_RFC      = 4'd6,
    ERR_RP       = 4'd7,
    ERR_RC       = 4'd8,
    ERR_RRD      = 4'd9,
    ERR_RCD      = 4'd10,
    ERR_RAS      = 4'd11
  } err_e;

  // Strobe decode; chip select high masks everything else.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_INH;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b110:  c = CMD_BST;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        default: c = CMD_LMR;
      endcase
    end
    return c;
  endfunction

  // Mode length field to burst cycles; zero means no automatic close.
  function automatic logic [LEN_W-1:0] burst_cycles(input logic [2:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      3'd0:    n = LEN_W'(1);
      3'd1:    n = LEN_W'(2);
      3'd2:    n = LEN_W'(4);
      3'd3:    n = LEN_W'(8);
      default: n = '0;
    endcase
    return n;
  endfunction

  function automatic logic is_exec(input cmd_e c);
    return !(c == CMD_INH || c == CMD_NOP);
  endfunction

endpackage

// File: rtl/sbm_bank_track.sv
`timescale 1ns/1ps
module sbm_bank_track
  import sbm_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_RC  = 10,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             a10,
  input  logic [LEN_W-1:0] rw_len,
  output logic             open_o,
  output logic             rcd_busy,
  output logic             ras_busy,
  output logic             rp_busy,
  output logic             rc_busy
);

  logic [CW-1:0]    rcd_q, ras_q, rp_q, rc_q;
  logic [LEN_W-1:0] ap_q;
  logic             open_q;

  // Named events for the assertions below.
  logic hit_act, hit_rw, hit_pre, ap_fire;
  assign hit_act = sel && (cmd == CMD_ACT);
  assign hit_rw  = sel && (cmd == CMD_RD || cmd == CMD_WR);
  assign hit_pre = (cmd == CMD_PRE) && (a10 || sel);
  assign ap_fire = (ap_q == LEN_W'(1));

  function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
    return (v == '0) ? v : v - CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rp_q   <= '0;
      rc_q   <= '0;
      ap_q   <= '0;
    end else begin
      rcd_q <= tick(rcd_q);
      ras_q <= tick(ras_q);
      rp_q  <= tick(rp_q);
      rc_q  <= tick(rc_q);
      ap_q  <= (ap_q == '0) ? ap_q : ap_q - LEN_W'(1);
      if (hit_act) begin
        open_q <= 1'b1;
        rcd_q  <= CW'(T_RCD - 1);
        ras_q  <= CW'(T_RAS - 1);
        rc_q   <= CW'(T_RC - 1);
        ap_q   <= '0;
      end else if (hit_pre) begin
        ap_q <= '0;
        if (open_q) begin
          open_q <= 1'b0;
          rp_q   <= CW'(T_RP - 1);
        end
      end else if (hit_rw) begin
        ap_q <= (open_q && a10) ? rw_len : '0;
      end else if (ap_fire) begin
        open_q <= 1'b0;
        rp_q   <= CW'(T_RP - 1);
      end
    end
  end

  assign open_o   = open_q;
  assign rcd_busy = (rcd_q != '0);
  assign ras_busy = (ras_q != '0);
  assign rp_busy  = (rp_q != '0);
  assign rc_busy  = (rc_q != '0);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_act |=> open_o);

  p_pre_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pre |=> !open_o);

  p_auto_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_fire && !hit_act && !hit_rw) |=> !open_o);

  p_idle_no_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !open_o |-> (ap_q == '0));

  if (T_RP > 1) begin : g_rp_chk
    p_close_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_o) |-> rp_busy);
  end

endmodule

// File: rtl/sbm_cmd_spacing.sv
`timescale 1ns/1ps
module sbm_cmd_spacing
  import sbm_pkg::*;
#(
  parameter int T_MRD = 2,
  parameter int T_RRD = 2,
  parameter int T_RFC = 7,
  parameter int CW    = 4,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  bank,
  input  logic [2:0]       bl_code,
  input  logic             wr_single,
  output logic             mrd_busy,
  output logic             rrd_busy,
  output logic             rfc_busy,
  output logic [LEN_W-1:0] rd_len,
  output logic [LEN_W-1:0] wr_len
);

  logic [CW-1:0]   mrd_q, rrd_q, rfc_q;
  logic [BA_W-1:0] last_act_q;
  logic [2:0]      bl_q;
  logic            ws_q;

  function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
    return (v == '0) ? v : v - CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd_q      <= '0;
      rrd_q      <= '0;
      rfc_q      <= '0;
      last_act_q <= '0;
      bl_q       <= 3'd0;
      ws_q       <= 1'b0;
    end else begin
      mrd_q <= tick(mrd_q);
      rrd_q <= tick(rrd_q);
      rfc_q <= tick(rfc_q);
      case (cmd)
        CMD_LMR: begin
          mrd_q <= CW'(T_MRD - 1);
          bl_q  <= bl_code;
          ws_q  <= wr_single;
        end
        CMD_ACT: begin
          rrd_q      <= CW'(T_RRD - 1);
          last_act_q <= bank;
        end
        CMD_REF: rfc_q <= CW'(T_RFC - 1);
        default: ;
      endcase
    end
  end

  assign mrd_busy = (mrd_q != '0);
  assign rfc_busy = (rfc_q != '0);
  assign rrd_busy = (rrd_q != '0) && (bank != last_act_q);
  assign rd_len   = burst_cycles(bl_q);
  assign wr_len   = ws_q ? LEN_W'(1) : burst_cycles(bl_q);

  if (T_MRD > 1) begin : g_mrd_chk
    p_mode_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LMR) |=> mrd_busy);
  end
  if (T_RFC > 1) begin : g_rfc_chk
    p_refresh_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_REF) |=> rfc_busy);
  end

endmodule

// File: rtl/sbm_rule_check.sv
`timescale 1ns/1ps
module sbm_rule_check
  import sbm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic                 a10,
  input  logic [NUM_BANKS-1:0] open_v,
  input  logic [NUM_BANKS-1:0] rcd_v,
  input  logic [NUM_BANKS-1:0] ras_v,
  input  logic [NUM_BANKS-1:0] rp_v,
  input  logic [NUM_BANKS-1:0] rc_v,
  input  logic                 mrd_busy,
  input  logic                 rrd_busy,
  input  logic                 rfc_busy,
  output logic                 viol,
  output err_e                 code,
  output logic [BA_W-1:0]      vbank
);

  function automatic logic [BA_W-1:0] lowest(input logic [NUM_BANKS-1:0] v);
    logic [BA_W-1:0] r;
    r = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (v[i]) r = BA_W'(i);
    end
    return r;
  endfunction

  logic [NUM_BANKS-1:0] ras_hit;
  assign ras_hit = open_v & ras_v;

  // Checks run in ascending code order so the first match wins.
  always_comb begin
    code  = ERR_NONE;
    vbank = bank;
    if (is_exec(cmd) && mrd_busy) begin
      code = ERR_MRD;
    end else begin
      case (cmd)
        CMD_RD, CMD_WR: begin
          if (!open_v[bank])    code = ERR_NOROW;
          else if (rcd_v[bank]) code = ERR_RCD;
        end
        CMD_ACT: begin
          if (open_v[bank])     code = ERR_ROWOPEN;
          else if (rfc_busy)    code = ERR_RFC;
          else if (rp_v[bank])  code = ERR_RP;
          else if (rc_v[bank])  code = ERR_RC;
          else if (rrd_busy)    code = ERR_RRD;
        end
        CMD_PRE: begin
          if (a10) begin
            if (|ras_hit) begin
              code  = ERR_RAS;
              vbank = lowest(ras_hit);
            end
          end else if (ras_hit[bank]) begin
            code = ERR_RAS;
          end
        end
        CMD_LMR: begin
          if (|open_v) begin
            code  = ERR_MODEBUSY;
            vbank = lowest(open_v);
          end
        end
        CMD_REF: begin
          if (|open_v) begin
            code  = ERR_REFBUSY;
            vbank = lowest(open_v);
          end
        end
        default: ;
      endcase
    end
  end

  assign viol = (code != ERR_NONE);

endmodule

// File: rtl/sdram_bank_monitor.sv
`timescale 1ns/1ps
module sdram_bank_monitor
  import sbm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 7,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 err_valid,
  output logic [3:0]           err_code,
  output logic [BA_W-1:0]      err_bank
);

  localparam int AP_BIT = 10;
  localparam int WS_BIT = 9;
  localparam int M1   = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int M2   = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int M3   = (T_RRD > T_MRD) ? T_RRD : T_MRD;
  localparam int M4   = (M1 > M2) ? M1 : M2;
  localparam int M5   = (M3 > T_RFC) ? M3 : T_RFC;
  localparam int TMAX = (M4 > M5) ? M4 : M5;
  localparam int CW   = $clog2(TMAX + 1);

  cmd_e cmd_d;
  logic a10;
  logic addr_unused;
  assign cmd_d       = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign a10         = addr[AP_BIT];
  assign addr_unused = ^addr;

  logic [NUM_BANKS-1:0] open_v, rcd_v, ras_v, rp_v, rc_v;
  logic [LEN_W-1:0]     rd_len, wr_len, rw_len;
  logic                 mrd_busy, rrd_busy, rfc_busy;
  assign rw_len = (cmd_d == CMD_WR) ? wr_len : rd_len;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    sbm_bank_track #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC), .CW(CW)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd_d),
      .sel      (ba == BA_W'(i)),
      .a10      (a10),
      .rw_len   (rw_len),
      .open_o   (open_v[i]),
      .rcd_busy (rcd_v[i]),
      .ras_busy (ras_v[i]),
      .rp_busy  (rp_v[i]),
      .rc_busy  (rc_v[i])
    );
  end

  sbm_cmd_spacing #(
    .T_MRD(T_MRD), .T_RRD(T_RRD), .T_RFC(T_RFC), .CW(CW), .BA_W(BA_W)
  ) u_space (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd_d),
    .bank      (ba),
    .bl_code   (addr[2:0]),
    .wr_single (addr[WS_BIT]),
    .mrd_busy  (mrd_busy),
    .rrd_busy  (rrd_busy),
    .rfc_busy  (rfc_busy),
    .rd_len    (rd_len),
    .wr_len    (wr_len)
  );

  logic            viol_now;
  err_e            code_now;
  logic [BA_W-1:0] vbank_now;

  sbm_rule_check #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_check (
    .cmd      (cmd_d),
    .bank     (ba),
    .a10      (a10),
    .open_v   (open_v),
    .rcd_v    (rcd_v),
    .ras_v    (ras_v),
    .rp_v     (rp_v),
    .rc_v     (rc_v),
    .mrd_busy (mrd_busy),
    .rrd_busy (rrd_busy),
    .rfc_busy (rfc_busy),
    .viol     (viol_now),
    .code     (code_now),
    .vbank    (vbank_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_code  <= 4'd0;
      err_bank  <= '0;
    end else begin
      err_valid <= viol_now;
      err_code  <= viol_now ? 4'(code_now) : 4'd0;
      err_bank  <= viol_now ? vbank_now : '0;
    end
  end

  assign bank_open = open_v;

  p_pulse_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |=> err_valid);

  p_quiet_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_now |=> !err_valid);

  p_idle_cmds_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_d == CMD_NOP || cmd_d == CMD_INH) |=> !err_valid);

  p_mode_while_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_d == CMD_LMR && |bank_open) |=> err_valid);

  p_access_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_d == CMD_RD || cmd_d == CMD_WR) && !bank_open[ba]) |=> err_valid);

endmodule

// File: tb/sdram_bank_monitor_tb_top.sv
`timescale 1ns/1ps
module sdram_bank_monitor_tb_top;

  localparam int NB = 4;
  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RC = 10;
  localparam int T_RRD = 2, T_MRD = 2, T_RFC = 7;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_LMR = 4'b0000, C_INH = 4'b1010;
  localparam logic [11:0] A10 = 12'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [NB-1:0] bank_open;
  logic err_valid;
  logic [3:0] err_code;
  logic [1:0] err_bank;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_bank_monitor #(
    .NUM_BANKS(NB), .ADDR_W(12), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RC(T_RC), .T_RRD(T_RRD), .T_MRD(T_MRD), .T_RFC(T_RFC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open),
    .err_valid(err_valid), .err_code(err_code), .err_bank(err_bank)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one command just after an edge; return just after the edge that takes it.
  task automatic send(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) send(C_NOP, 2'd0, 12'd0);
  endtask

  task automatic do_reset();
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic expect_err(input string req, input int code, input int bank);
    check(req, err_valid ? int'(err_code) : 0, code);
    if (code != 0) check({req, " bank"}, int'(err_bank), bank);
  endtask

  initial begin
    do_reset();
    // R10: reset state
    check("R10 open after reset", int'(bank_open), 0);
    check("R10 err after reset", int'(err_valid), 0);

    // R1: deselect with PRECHARGE-all look does nothing
    send(C_ACT, 2'd1, 12'd5);
    nops(T_RAS);
    send(C_INH, 2'd1, A10);
    check("R1 inhibit no close", int'(bank_open), 2);
    expect_err("R1 inhibit no err", 0, 0);
    send(C_NOP, 2'd1, A10);
    check("R1 nop no close", int'(bank_open), 2);
    expect_err("R1 nop no err", 0, 0);

    // R6: ACTIVE to READ spacing, every bank
    for (int b = 0; b < NB; b++) begin
      for (int g = 1; g <= T_RCD + 1; g++) begin
        do_reset();
        send(C_ACT, 2'(b), 12'd7);
        nops(g - 1);
        send(C_RD, 2'(b), 12'd0);
        expect_err("R6 tRCD", (g < T_RCD) ? 10 : 0, b);
        send(C_NOP, 2'd0, 12'd0);
        check("R9 single pulse", int'(err_valid), 0);
      end
    end

    // R6: ACTIVE to PRECHARGE spacing
    for (int g = 1; g <= T_RAS + 1; g++) begin
      do_reset();
      send(C_ACT, 2'd2, 12'd1);
      nops(g - 1);
      send(C_PRE, 2'd2, 12'd0);
      expect_err("R6 tRAS", (g < T_RAS) ? 11 : 0, 2);
      check("R3 closed after pre", int'(bank_open), 0);
    end

    // R6: close to ACTIVE and ACTIVE to ACTIVE
    for (int g = 1; g <= T_RC; g++) begin
      do_reset();
      send(C_ACT, 2'd1, 12'd1);
      nops(T_RAS - 1);
      send(C_PRE, 2'd1, 12'd0);
      nops(g - 1);
      send(C_ACT, 2'd1, 12'd2);
      expect_err("R6 tRP/tRC", (g < T_RP) ? 7 : ((T_RAS + g < T_RC) ? 8 : 0), 1);
    end

    // R7: ACTIVE spacing across banks
    for (int g = 1; g <= T_RRD + 1; g++) begin
      do_reset();
      send(C_ACT, 2'd0, 12'd1);
      nops(g - 1);
      send(C_ACT, 2'd3, 12'd1);
      expect_err("R7 tRRD", (g < T_RRD) ? 9 : 0, 3);
    end

    // R8: REFRESH to ACTIVE
    for (int g = 1; g <= T_RFC + 1; g++) begin
      do_reset();
      send(C_REF, 2'd0, 12'd0);
      expect_err("R8 idle refresh", 0, 0);
      nops(g - 1);
      send(C_ACT, 2'd3, 12'd0);
      expect_err("R8 tRFC", (g < T_RFC) ? 6 : 0, 3);
    end

    // R5: MODE LOAD to next command
    for (int g = 1; g <= T_MRD + 1; g++) begin
      do_reset();
      send(C_LMR, 2'd0, 12'd0);
      nops(g - 1);
      send(C_ACT, 2'd2, 12'd0);
      expect_err("R5 tMRD", (g < T_MRD) ? 1 : 0, 2);
    end

    // R2: access to idle bank, ACTIVE to open bank
    do_reset();
    send(C_RD, 2'd2, 12'd0);
    expect_err("R2 read idle", 2, 2);
    send(C_WR, 2'd3, 12'd0);
    expect_err("R2 write idle", 2, 3);
    send(C_ACT, 2'd0, 12'd0);
    nops(T_RC - 1);
    send(C_ACT, 2'd0, 12'd9);
    expect_err("R2 act open", 3, 0);
    check("R2 still open", int'(bank_open), 1);

    // R9: priority, row-open beats tRC; mode wait beats no-row
    do_reset();
    send(C_ACT, 2'd1, 12'd0);
    send(C_NOP, 2'd0, 12'd0);
    send(C_ACT, 2'd1, 12'd0);
    expect_err("R9 open over tRC", 3, 1);
    do_reset();
    send(C_LMR, 2'd0, 12'd0);
    send(C_RD, 2'd0, 12'd0);
    expect_err("R9 mrd over norow", 1, 0);

    // R5 / R8: mode load and refresh with rows open report lowest bank
    do_reset();
    send(C_ACT, 2'd3, 12'd0);
    nops(T_RRD - 1);
    send(C_ACT, 2'd1, 12'd0);
    nops(T_RAS);
    send(C_LMR, 2'd0, 12'd0);
    expect_err("R5 mode busy", 4, 1);
    nops(T_MRD);
    send(C_REF, 2'd0, 12'd0);
    expect_err("R8 refresh busy", 5, 1);

    // R3: single and all-bank precharge
    do_reset();
    for (int b = 0; b < NB; b++) begin
      send(C_ACT, 2'(b), 12'd3);
      nops(T_RRD - 1);
    end
    check("R2 all open", int'(bank_open), 15);
    nops(T_RAS);
    send(C_PRE, 2'd0, 12'd0);
    check("R3 single close", int'(bank_open), 14);
    expect_err("R3 single no err", 0, 0);
    send(C_PRE, 2'd0, 12'd0);
    expect_err("R3 idle pre legal", 0, 0);
    send(C_PRE, 2'd0, A10);
    check("R3 all close", int'(bank_open), 0);
    expect_err("R3 all no err", 0, 0);

    // R6: early precharge-all names lowest offending bank
    do_reset();
    send(C_ACT, 2'd0, 12'd0);
    nops(T_RRD - 1);
    send(C_ACT, 2'd1, 12'd0);
    nops(T_RAS - T_RRD - 1);
    send(C_PRE, 2'd3, A10);
    expect_err("R6 pre-all tRAS", 11, 1);
    check("R3 pre-all closes", int'(bank_open), 0);

    // R4: automatic close for each fixed burst length, read
    for (int k = 0; k < 4; k++) begin
      int bl;
      bl = 1 << k;
      do_reset();
      send(C_LMR, 2'd0, 12'(k));
      nops(T_MRD - 1);
      send(C_ACT, 2'd1, 12'd0);
      nops(T_RCD - 1);
      send(C_RD, 2'd1, A10);
      expect_err("R4 read ap", 0, 0);
      for (int j = 0; j <= bl; j++) begin
        if (j > 0) send(C_NOP, 2'd0, 12'd0);
        check("R4 auto close timing", int'(bank_open[1]), (j < bl) ? 1 : 0);
      end
    end

    // R10: reset mode closes after one cycle
    do_reset();
    send(C_ACT, 2'd2, 12'd0);
    nops(T_RCD - 1);
    send(C_WR, 2'd2, A10);
    check("R10 default len open", int'(bank_open[2]), 1);
    send(C_NOP, 2'd0, 12'd0);
    check("R10 default len closed", int'(bank_open[2]), 0);

    // R4: full page never closes; no flag never closes
    do_reset();
    send(C_LMR, 2'd0, 12'd7);
    nops(T_MRD - 1);
    send(C_ACT, 2'd0, 12'd0);
    nops(T_RCD - 1);
    send(C_RD, 2'd0, A10);
    nops(20);
    check("R4 full page stays", int'(bank_open[0]), 1);
    send(C_RD, 2'd0, 12'd0);
    nops(20);
    check("R4 no flag stays", int'(bank_open[0]), 1);

    // R4: single-write mode
    do_reset();
    send(C_LMR, 2'd0, 12'h203);
    nops(T_MRD - 1);
    send(C_ACT, 2'd3, 12'd0);
    nops(T_RCD - 1);
    send(C_WR, 2'd3, A10);
    check("R4 single write open", int'(bank_open[3]), 1);
    send(C_NOP, 2'd0, 12'd0);
    check("R4 single write closed", int'(bank_open[3]), 0);
    do_reset();
    send(C_LMR, 2'd0, 12'h203);
    nops(T_MRD - 1);
    send(C_ACT, 2'd3, 12'd0);
    nops(T_RCD - 1);
    send(C_RD, 2'd3, A10);
    nops(7);
    check("R4 read keeps length", int'(bank_open[3]), 1);
    send(C_NOP, 2'd0, 12'd0);
    check("R4 read closes at 8", int'(bank_open[3]), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule